// File: doc/BRIEF.md
# Playback Slot Demultiplexer

This block sits behind the deserializer of a time-slotted audio frame. It receives one 16-bit slot word per strobe, tagged with its slot index. From those words it collects a control word and the playback sample slots of two DAC channels. When the frame closes, it decides for each DAC whether that frame's samples are taken. A sample set is taken only if the control word marked that DAC valid and the DAC raised a data request in the previous frame. Each taken set is converted to a 16-bit signed left/right pair and presented on the outputs, together with a one-cycle strobe.

Each DAC has its own stereo/mono selector. In mono mode the left slot feeds both output channels. One format selector applies to both DACs and chooses among 16-bit signed linear, 8-bit unsigned linear and 8-bit companded samples. The 8-bit formats are carried in the upper byte of the slot. Companded bytes are passed on, left-aligned, with no expansion. Slot positions repeat every 16 slots, so a frame that starts at slot 16 maps the same way as one that starts at slot 0.

Top module: `pb_slot_demux`

## Requirements
- R1: After reset, all sample outputs are zero, no strobe is raised, and both request latches are clear, so the first frame after reset delivers nothing.
- R2: Within a frame, slot offsets (the index modulo 16) 2 and 3 carry the DAC1 left and right samples, and offsets 4 and 5 carry the DAC2 left and right samples. Index bit 4 has no effect.
- R3: The control word arrives at slot offset 0. Its bit 0 is the DAC1 valid flag and its bit 1 is the DAC2 valid flag.
- R4: A DAC whose valid flag is 0 in a frame gets no strobe for that frame, and its outputs keep their previous values.
- R5: The request input of each DAC is sampled in the frame-end cycle and applies to the following frame. A valid flag of 1 has no effect if the request sampled at the previous frame end was 0.
- R6: An accepted DAC updates its left and right outputs, and raises its strobe for exactly one cycle, on the clock edge that samples frame_end_i.
- R7: In mono mode (dac_mono_i bit set, sampled at frame end), the left slot drives both outputs and the right slot is ignored.
- R8: With format 0 (16-bit signed), the slot word is output unchanged.
- R9: With format 1 (8-bit unsigned), the output is {~slot[15], slot[14:8], 8'h00}. Slot bits 7:0 are ignored.
- R10: With format 2 (8-bit companded), the output is {slot[15:8], 8'h00}. Format 3 behaves as format 0.
- R11: Slot offsets 1 and 6 to 15 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_stb_i | input | 1 | Slot word present this cycle |
| slot_idx_i | input | 5 | Slot index of the word |
| slot_data_i | input | 16 | Slot word |
| frame_end_i | input | 1 | One-cycle pulse closing the frame |
| dac_req_i | input | 2 | Per-DAC data request raised this frame |
| dac_mono_i | input | 2 | Per-DAC mono select |
| fmt_i | input | 2 | Sample format: 0 S16, 1 U8, 2 8-bit companded, 3 as 0 |
| dac_left_o | output | 32 | Left samples, DAC1 in bits 15:0 |
| dac_right_o | output | 32 | Right samples, DAC1 in bits 15:0 |
| dac_stb_o | output | 2 | Per-DAC one-cycle delivery strobe |

## Verification
A stale request latch shows up one frame late: a strobe appears where none should, or a strobe is missing, at the end of the frame that follows the request change. A wrongly decoded slot offset or control bit swaps or corrupts output words at the very next accepted frame end. A holding register written by an ignored slot does not change the outputs until a later accepted frame, so every frame carries junk in the unused slots and ends with a check that the outputs did not move. Conversion faults are visible in the upper or lower byte of the first strobed sample in each format.

// File: rtl/pb_slot_pkg.sv
package pb_slot_pkg;
  typedef enum logic [1:0] {
    FMT_S16 = 2'd0,
    FMT_U8  = 2'd1,
    FMT_C8  = 2'd2,
    FMT_RSV = 2'd3
  } fmt_e;
endpackage

// File: rtl/pb_sample_conv.sv
module pb_sample_conv
  import pb_slot_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] raw_i,
  input  fmt_e         fmt_i,
  output logic [W-1:0] smp_o
);
  localparam int HALF = W / 2;

  always_comb begin
    unique case (fmt_i)
      FMT_U8:  smp_o = {~raw_i[W-1], raw_i[W-2:HALF], {HALF{1'b0}}};
      FMT_C8:  smp_o = {raw_i[W-1:HALF], {HALF{1'b0}}};
      default: smp_o = raw_i;
    endcase
  end
endmodule

// File: rtl/pb_ctl_capture.sv
module pb_ctl_capture #(
  parameter int NUM_DAC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctl_we_i,
  input  logic [NUM_DAC-1:0] ctl_bits_i,
  input  logic               frame_end_i,
  output logic [NUM_DAC-1:0] vflag_o
);
  // flags live for one frame only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          vflag_o <= '0;
    else if (frame_end_i) vflag_o <= '0;
    else if (ctl_we_i)    vflag_o <= ctl_bits_i;
  end
endmodule

// File: rtl/pb_dac_lane.sv
module pb_dac_lane
  import pb_slot_pkg::*;
#(
  parameter int W         = 16,
  parameter int OFS_W     = 4,
  parameter int LEFT_SLOT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slot_stb_i,
  input  logic [OFS_W-1:0] slot_ofs_i,
  input  logic [W-1:0]     slot_data_i,
  input  logic             frame_end_i,
  input  logic             vflag_i,
  input  logic             req_i,
  input  logic             mono_i,
  input  fmt_e             fmt_i,
  output logic [W-1:0]     left_o,
  output logic [W-1:0]     right_o,
  output logic             stb_o
);
  localparam logic [OFS_W-1:0] OFS_L = OFS_W'(LEFT_SLOT);
  localparam logic [OFS_W-1:0] OFS_R = OFS_W'(LEFT_SLOT + 1);

  logic [W-1:0] hold_l, hold_r, conv_l, conv_r;
  logic         req_q, accept;

  assign accept = frame_end_i & vflag_i & req_q;

  pb_sample_conv #(.W(W)) u_conv_l (
    .raw_i(hold_l),
    .fmt_i(fmt_i),
    .smp_o(conv_l)
  );

  pb_sample_conv #(.W(W)) u_conv_r (
    .raw_i(mono_i ? hold_l : hold_r),
    .fmt_i(fmt_i),
    .smp_o(conv_r)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_l <= '0;
      hold_r <= '0;
    end else if (slot_stb_i) begin
      if (slot_ofs_i == OFS_L) hold_l <= slot_data_i;
      if (slot_ofs_i == OFS_R) hold_r <= slot_data_i;
    end
  end

  // request raised this frame governs the next one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          req_q <= 1'b0;
    else if (frame_end_i) req_q <= req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_o  <= '0;
      right_o <= '0;
      stb_o   <= 1'b0;
    end else begin
      stb_o <= accept;
      if (accept) begin
        left_o  <= conv_l;
        right_o <= conv_r;
      end
    end
  end
endmodule

// File: rtl/pb_slot_demux.sv
module pb_slot_demux
  import pb_slot_pkg::*;
#(
  parameter int NUM_DAC    = 2,
  parameter int SAMPLE_W   = 16,
  parameter int SLOT_IDX_W = 5,
  parameter int FIRST_SLOT = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         slot_stb_i,
  input  logic [SLOT_IDX_W-1:0]        slot_idx_i,
  input  logic [SAMPLE_W-1:0]          slot_data_i,
  input  logic                         frame_end_i,
  input  logic [NUM_DAC-1:0]           dac_req_i,
  input  logic [NUM_DAC-1:0]           dac_mono_i,
  input  logic [1:0]                   fmt_i,
  output logic [NUM_DAC*SAMPLE_W-1:0]  dac_left_o,
  output logic [NUM_DAC*SAMPLE_W-1:0]  dac_right_o,
  output logic [NUM_DAC-1:0]           dac_stb_o
);
  localparam int OFS_W = SLOT_IDX_W - 1;

  logic [OFS_W-1:0]   slot_ofs;
  logic [NUM_DAC-1:0] vflag;
  logic               ctl_we;
  fmt_e               fmt;
  logic               unused_bits;

  // upper index bit selects the alternate half; layout is identical
  assign slot_ofs    = slot_idx_i[OFS_W-1:0];
  assign ctl_we      = slot_stb_i & (slot_ofs == '0);
  assign fmt         = fmt_e'(fmt_i);
  assign unused_bits = ^{slot_idx_i[SLOT_IDX_W-1], slot_data_i[SAMPLE_W-1:NUM_DAC]};

  pb_ctl_capture #(.NUM_DAC(NUM_DAC)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_we_i   (ctl_we),
    .ctl_bits_i (slot_data_i[NUM_DAC-1:0]),
    .frame_end_i(frame_end_i),
    .vflag_o    (vflag)
  );

  for (genvar d = 0; d < NUM_DAC; d++) begin : g_lane
    pb_dac_lane #(
      .W        (SAMPLE_W),
      .OFS_W    (OFS_W),
      .LEFT_SLOT(FIRST_SLOT + 2 * d)
    ) u_lane (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .slot_stb_i (slot_stb_i),
      .slot_ofs_i (slot_ofs),
      .slot_data_i(slot_data_i),
      .frame_end_i(frame_end_i),
      .vflag_i    (vflag[d]),
      .req_i      (dac_req_i[d]),
      .mono_i     (dac_mono_i[d]),
      .fmt_i      (fmt),
      .left_o     (dac_left_o[d*SAMPLE_W +: SAMPLE_W]),
      .right_o    (dac_right_o[d*SAMPLE_W +: SAMPLE_W]),
      .stb_o      (dac_stb_o[d])
    );
  end
endmodule

// File: rtl/pb_slot_demux_chk.sv
module pb_slot_demux_chk #(
  parameter int NUM_DAC  = 2,
  parameter int SAMPLE_W = 16
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        frame_end_i,
  input logic [NUM_DAC-1:0]          dac_req_i,
  input logic [NUM_DAC-1:0]          dac_mono_i,
  input logic [1:0]                  fmt_i,
  input logic [NUM_DAC*SAMPLE_W-1:0] dac_left_o,
  input logic [NUM_DAC*SAMPLE_W-1:0] dac_right_o,
  input logic [NUM_DAC-1:0]          dac_stb_o
);
  localparam int HALF = SAMPLE_W / 2;

  logic [NUM_DAC-1:0] req_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          req_seen <= '0;
    else if (frame_end_i) req_seen <= dac_req_i;
  end

  for (genvar d = 0; d < NUM_DAC; d++) begin : g_chk
    AST_STB_AT_FRAME_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dac_stb_o[d] |-> $past(frame_end_i)); // R6

    AST_HOLD_WITHOUT_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !dac_stb_o[d] |-> ($stable(dac_left_o[d*SAMPLE_W +: SAMPLE_W])
                         && $stable(dac_right_o[d*SAMPLE_W +: SAMPLE_W]))); // R4

    AST_NO_REQ_NO_STB: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frame_end_i && !req_seen[d]) |=> !dac_stb_o[d]); // R5

    AST_MONO_DUPLICATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dac_stb_o[d] && $past(dac_mono_i[d])) |->
        (dac_left_o[d*SAMPLE_W +: SAMPLE_W] == dac_right_o[d*SAMPLE_W +: SAMPLE_W])); // R7

    AST_U8_LOW_BYTE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dac_stb_o[d] && ($past(fmt_i) == 2'd1)) |->
        ((dac_left_o[d*SAMPLE_W +: HALF] == '0) && (dac_right_o[d*SAMPLE_W +: HALF] == '0))); // R9
  end
endmodule

bind pb_slot_demux pb_slot_demux_chk #(
  .NUM_DAC (NUM_DAC),
  .SAMPLE_W(SAMPLE_W)
) u_chk (.*);

// File: tb/pb_slot_demux_tb.sv
module pb_slot_demux_tb;
  typedef struct {
    logic [15:0] l;
    logic [15:0] r;
    string       tag;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        slot_stb_i = 1'b0;
  logic [4:0]  slot_idx_i = '0;
  logic [15:0] slot_data_i = '0;
  logic        frame_end_i = 1'b0;
  logic [1:0]  dac_req_i = '0;
  logic [1:0]  dac_mono_i = '0;
  logic [1:0]  fmt_i = '0;
  logic [31:0] dac_left_o, dac_right_o;
  logic [1:0]  dac_stb_o;

  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  item_t q0[$];
  item_t q1[$];
  logic [1:0]  req_model = '0;
  logic [15:0] hold_l[2];
  logic [15:0] hold_r[2];

  always #10 clk_i = ~clk_i;

  pb_slot_demux u_dut (.*);

  function automatic logic [15:0] exp_conv(logic [15:0] r, logic [1:0] f);
    case (f)
      2'd1:    return {~r[15], r[14:8], 8'h00};
      2'd2:    return {r[15:8], 8'h00};
      default: return r;
    endcase
  endfunction

  task automatic check(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", msg, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: pop on every strobe
  always @(negedge clk_i) begin
    if (rst_ni) begin
      for (int d = 0; d < 2; d++) begin
        if (dac_stb_o[d]) begin
          item_t it;
          logic [31:0] act;
          act = {dac_left_o[d*16 +: 16], dac_right_o[d*16 +: 16]};
          if ((d == 0 ? q0.size() : q1.size()) == 0) begin
            check(1'b0, $sformatf("R4 R5 unexpected strobe dac%0d", d), act, 32'h0);
          end else begin
            it = (d == 0) ? q0.pop_front() : q1.pop_front();
            check(act == {it.l, it.r}, $sformatf("%s dac%0d sample", it.tag, d), act, {it.l, it.r});
          end
        end
      end
    end
  end

  // watchdog
  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 20000) begin
      check(1'b0, "watchdog expired", 32'(cyc), 32'h0);
      finish_run();
    end
  end

  task automatic run_frame(input logic [1:0] ctl, input logic [15:0] s2, input logic [15:0] s3,
                           input logic [15:0] s4, input logic [15:0] s5, input logic [1:0] req,
                           input logic [1:0] mono, input logic [1:0] fmt, input bit alt,
                           input string tag);
    logic [15:0] sl[2];
    logic [15:0] sr[2];
    sl[0] = s2; sr[0] = s3; sl[1] = s4; sr[1] = s5;
    @(negedge clk_i);
    dac_mono_i = mono;
    fmt_i      = fmt;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i);
      slot_stb_i = 1'b1;
      slot_idx_i = 5'(i + (alt ? 16 : 0));
      case (i)
        0:       slot_data_i = {14'h0, ctl};
        2:       slot_data_i = s2;
        3:       slot_data_i = s3;
        4:       slot_data_i = s4;
        5:       slot_data_i = s5;
        default: slot_data_i = 16'hC3C3 ^ (16'(i) * 16'h0101);  // R11 junk
      endcase
    end
    @(negedge clk_i);
    slot_stb_i  = 1'b0;
    frame_end_i = 1'b1;
    dac_req_i   = req;
    for (int d = 0; d < 2; d++) begin
      if (ctl[d] && req_model[d]) begin
        item_t it;
        it.l   = exp_conv(sl[d], fmt);
        it.r   = mono[d] ? exp_conv(sl[d], fmt) : exp_conv(sr[d], fmt);
        it.tag = tag;
        hold_l[d] = it.l;
        hold_r[d] = it.r;
        if (d == 0) q0.push_back(it); else q1.push_back(it);
      end
    end
    req_model = req;
    @(negedge clk_i);
    frame_end_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check((q0.size() + q1.size()) == 0, {"R6 missing strobe: ", tag},
          32'(q0.size() + q1.size()), 32'h0);
    for (int d = 0; d < 2; d++) begin
      logic [31:0] act;
      act = {dac_left_o[d*16 +: 16], dac_right_o[d*16 +: 16]};
      check(act == {hold_l[d], hold_r[d]}, $sformatf("R4 R11 held output dac%0d: %s", d, tag),
            act, {hold_l[d], hold_r[d]});
    end
  endtask

  initial begin
    hold_l[0] = '0; hold_l[1] = '0; hold_r[0] = '0; hold_r[1] = '0;
    repeat (3) @(negedge clk_i);
    check(dac_left_o == '0 && dac_right_o == '0, "R1 outputs zero in reset",
          dac_left_o | dac_right_o, 32'h0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(dac_stb_o == '0, "R1 no strobe after reset", 32'(dac_stb_o), 32'h0);

    run_frame(2'b11, 16'h1111, 16'h2222, 16'h3333, 16'h4444, 2'b11, 2'b00, 2'd0, 1'b0,
              "R1 R5 first frame no request");
    run_frame(2'b11, 16'h8123, 16'h7FFF, 16'h0001, 16'hFFFF, 2'b01, 2'b00, 2'd0, 1'b0,
              "R2 R3 R6 R8 stereo s16");
    run_frame(2'b11, 16'h0F0F, 16'hF0F0, 16'h5A5A, 16'hA5A5, 2'b11, 2'b00, 2'd0, 1'b0,
              "R5 dac2 not requested");
    run_frame(2'b01, 16'h1357, 16'h2468, 16'h7777, 16'h8888, 2'b11, 2'b00, 2'd3, 1'b0,
              "R4 R3 R10 dac2 flag clear fmt3");
    run_frame(2'b11, 16'h80FF, 16'h1234, 16'h00AA, 16'h5555, 2'b11, 2'b11, 2'd1, 1'b1,
              "R7 R9 R2 mono u8 alt half");
    run_frame(2'b10, 16'h4444, 16'h4444, 16'h9A77, 16'h5311, 2'b11, 2'b00, 2'd2, 1'b0,
              "R10 R4 companded dac2 only");
    run_frame(2'b00, 16'hDEAD, 16'hBEEF, 16'hCAFE, 16'hF00D, 2'b11, 2'b00, 2'd0, 1'b0,
              "R4 R11 both flags clear");
    run_frame(2'b11, 16'h7F00, 16'h8001, 16'h0102, 16'hFEDC, 2'b00, 2'b10, 2'd0, 1'b1,
              "R7 R8 R11 dac2 mono s16");
    run_frame(2'b11, 16'h6666, 16'h6666, 16'h6666, 16'h6666, 2'b00, 2'b00, 2'd0, 1'b0,
              "R5 request withdrawn");
    finish_run();
  end
endmodule